// File: doc/BRIEF.md
# Edge-Triggered Pin Event Reporter

This block watches one auxiliary input pin and tells the host when it changes, so the host does not have to poll the pin's level. Each enabled edge produces a one-byte report. The report goes to the arbiter that merges traffic on the host-bound byte stream, over a valid/ready handshake. Reports travel without a request from the host. Their bit pattern is kept apart from every command response, so the host can recognise them wherever they land in the stream.

The host picks the edge mode with a one-byte configuration command, and the block acknowledges that command. The modes are: off, rising only, falling only, or both. The pin is asynchronous and passes through a synchroniser before edge detection. Reports that the arbiter has not yet accepted wait in a short FIFO. If an edge arrives while the FIFO is full, that report is dropped and a sticky loss flag is raised. Turning the mode off flushes every waiting report.

Top module: `pin_event_reporter`

## Requirements
- R1: After reset, `evt_valid`, `ack_valid` and `lost_event` are 0 and the mode is off, so pin edges produce no report until a configuration command enables one.
- R2: A command byte of the form 011000mm (0x60 to 0x63) sets the mode from mm: 00 off, 01 rising, 10 falling, 11 both. On the cycle after it is taken, `ack_valid` is 1 for exactly one cycle and `ack_byte` is 0x01.
- R3: Any other command byte is ignored. It produces no acknowledgement and leaves the mode unchanged.
- R4: In rising mode, a low-to-high pin change queues the report 0x31 and a high-to-low change queues nothing. Every report has the form 0011000d, with bit 0 equal to 1 for a rising edge and 0 for a falling edge.
- R5: In falling mode, a high-to-low pin change queues the report 0x30 and a low-to-high change queues nothing.
- R6: In both-edges mode, every pin change queues a report, 0x31 for a rise and 0x30 for a fall.
- R7: When the mode is off no reports are queued. A command that selects off discards every pending report, so `evt_valid` is 0 on the following cycle.
- R8: Reports leave in the order their edges occurred. While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid` stays 1 and `evt_byte` holds its value.
- R9: Up to 4 reports wait unaccepted. An edge that finds 4 reports waiting is dropped and sets `lost_event`. The flag stays 1 until the next accepted configuration command clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| aux_pin | input | 1 | Monitored pin, asynchronous to clk |
| cmd_valid | input | 1 | Host command byte present this cycle |
| cmd_byte | input | 8 | Host command byte |
| evt_ready | input | 1 | Stream arbiter accepts the report byte |
| evt_valid | output | 1 | A report byte is offered |
| evt_byte | output | 8 | Report byte 0011000d |
| ack_valid | output | 1 | One-cycle acknowledgement of a configuration command |
| ack_byte | output | 8 | Acknowledgement code, 0x01 while ack_valid is 1 |
| lost_event | output | 1 | Sticky flag: a report was dropped because the FIFO was full |

## Verification
Some properties can be checked on every cycle, and the assertions do so. They confirm the acknowledgement after each configuration byte and its absence after any other byte. They check the fixed report prefix, that a stalled report keeps its value, the flush on the off command, and that the loss flag stays set between configuration commands. Other behaviour depends on a history of pin changes and shows only in the bench's scenarios. That covers which edge each mode reports, the arrival order of queued reports, the exact set kept when the FIFO overflows, and the silence that follows a flush.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  localparam logic [5:0] CFG_PREFIX = 6'b011000;
  localparam logic [6:0] RPT_PREFIX = 7'b0011000;
  localparam logic [7:0] ACK_CODE   = 8'h01;
endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pe_edge_filter.sv
module pe_edge_filter
  import pin_event_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  edge_mode_e mode,
  output logic       hit,
  output logic       rising
);
  logic prev_q;
  logic rise_w;
  logic fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_comb begin
    rise_w = level & ~prev_q;
    fall_w = ~level & prev_q;
    rising = rise_w;
    unique case (mode)
      EDGE_RISE: hit = rise_w;
      EDGE_FALL: hit = fall_w;
      EDGE_ANY:  hit = rise_w | fall_w;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pe_event_fifo.sv
module pe_event_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic             do_push, do_pop, full_w;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    full_w  = (cnt_q == FULL_CNT);
    do_pop  = pop && (cnt_q != '0) && !flush;
    do_push = push && !flush && (!full_w || do_pop);
    drop    = push && !flush && full_w && !do_pop;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic we;
    assign we = do_push && (wr_q == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (we) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[rd_q];
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/pin_event_reporter.sv
module pin_event_reporter
  import pin_event_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_pin,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       evt_ready,
  output logic       evt_valid,
  output logic [7:0] evt_byte,
  output logic       ack_valid,
  output logic [7:0] ack_byte,
  output logic       lost_event
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       pin_sync;
  logic       edge_hit, edge_rising;
  edge_mode_e mode_q, mode_d;
  logic       cfg_hit, flush, push, pop, empty, drop;
  logic       ack_q, ack_d, lost_q, lost_d;
  logic [7:0] rpt_byte;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(aux_pin), .q(pin_sync)
  );

  pe_edge_filter u_edge (
    .clk(clk), .rst_n(rst_int_n), .level(pin_sync), .mode(mode_q),
    .hit(edge_hit), .rising(edge_rising)
  );

  always_comb begin
    cfg_hit  = cmd_valid && (cmd_byte[7:2] == CFG_PREFIX);
    flush    = cfg_hit && (cmd_byte[1:0] == EDGE_OFF);
    mode_d   = cfg_hit ? edge_mode_e'(cmd_byte[1:0]) : mode_q;
    push     = edge_hit;
    pop      = evt_valid && evt_ready;
    rpt_byte = {RPT_PREFIX, edge_rising};
    ack_d    = cfg_hit;
    lost_d   = cfg_hit ? 1'b0 : (lost_q | drop);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= EDGE_OFF;
      ack_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ack_q  <= ack_d;
      lost_q <= lost_d;
    end
  end

  pe_event_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .push(push), .wdata(rpt_byte),
    .pop(pop), .flush(flush), .rdata(evt_byte), .empty(empty), .drop(drop)
  );

  assign evt_valid  = !empty;
  assign ack_valid  = ack_q;
  assign ack_byte   = ack_q ? ACK_CODE : 8'h00;
  assign lost_event = lost_q;
endmodule

// File: rtl/pe_checker.sv
module pe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       evt_ready,
  input logic       evt_valid,
  input logic [7:0] evt_byte,
  input logic       ack_valid,
  input logic [7:0] ack_byte,
  input logic       lost_event
);
  logic cfg;
  assign cfg = cmd_valid && (cmd_byte[7:2] == 6'b011000);

  assert_cfg_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg |=> (ack_valid && ack_byte == 8'h01));

  assert_other_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cfg) |=> !ack_valid);

  assert_report_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_byte[7:1] == 7'b0011000));

  assert_off_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg && cmd_byte[1:0] == 2'b00) |=> !evt_valid);

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready && !cfg) |=> (evt_valid && $stable(evt_byte)));

  assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_event && !cfg) |=> lost_event);

  assert_lost_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg |=> !lost_event);
endmodule

bind pin_event_reporter pe_checker u_chk (
  .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .evt_ready(evt_ready), .evt_valid(evt_valid), .evt_byte(evt_byte),
  .ack_valid(ack_valid), .ack_byte(ack_byte), .lost_event(lost_event)
);

// File: tb/sim_pin_event_reporter.sv
module sim_pin_event_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n, aux_pin, cmd_valid, evt_ready;
  logic [7:0] cmd_byte;
  logic       evt_valid, ack_valid, lost_event;
  logic [7:0] evt_byte, ack_byte;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  logic [7:0] exp_q[$];
  logic [1:0] bm_mode = 2'b00;
  logic       exp_lost = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_reporter u0 (
    .clk(clk), .rst_n(rst_n), .aux_pin(aux_pin), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .evt_ready(evt_ready), .evt_valid(evt_valid),
    .evt_byte(evt_byte), .ack_valid(ack_valid), .ack_byte(ack_byte),
    .lost_event(lost_event)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard at each accepted report
  always @(negedge clk) begin
    if (rst_n && evt_valid && evt_ready) begin
      if (exp_q.size() == 0) chk("R7 unexpected report", evt_byte, 8'hxx);
      else chk("R8 report order/value", evt_byte, exp_q.pop_front());
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: move the pin and push the report the requirements call for
  task automatic pin_to(input logic v);
    logic rise;
    logic want;
    rise = v & ~aux_pin;
    want = (v !== aux_pin) &&
           ((bm_mode == 2'b11) || (bm_mode == 2'b01 && rise) || (bm_mode == 2'b10 && !rise));
    @(posedge clk); #1 aux_pin = v;
    if (want) begin
      if (exp_q.size() < DEPTH) exp_q.push_back({7'b0011000, rise});
      else exp_lost = 1'b1;
    end
    wait_cyc(8);
  endtask

  task automatic send_cmd(input logic [7:0] b);
    logic cfg;
    cfg = (b[7:2] == 6'b011000);
    @(posedge clk); #1 cmd_valid = 1'b1; cmd_byte = b;
    @(posedge clk); #1 cmd_valid = 1'b0; cmd_byte = 8'h00;
    if (cfg) begin
      bm_mode  = b[1:0];
      exp_lost = 1'b0;
      if (b[1:0] == 2'b00) exp_q.delete();
      chk("R2 ack_valid", {7'b0, ack_valid}, 8'h01);
      chk("R2 ack_byte", ack_byte, 8'h01);
    end else begin
      chk("R3 no ack", {7'b0, ack_valid}, 8'h00);
    end
    wait_cyc(1);
    chk("R2 ack one cycle", {7'b0, ack_valid}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; aux_pin = 1'b0; cmd_valid = 1'b0; cmd_byte = 8'h00; evt_ready = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1 reset state, mode off
    chk("R1 evt_valid", {7'b0, evt_valid}, 8'h00);
    chk("R1 ack_valid", {7'b0, ack_valid}, 8'h00);
    chk("R1 lost_event", {7'b0, lost_event}, 8'h00);
    pin_to(1'b1); pin_to(1'b0);
    chk("R1 no report while off", {7'b0, evt_valid}, 8'h00);

    // R3 foreign bytes ignored, mode stays off
    send_cmd(8'h64);
    send_cmd(8'h31);
    pin_to(1'b1); pin_to(1'b0);
    chk("R3 mode unchanged", {7'b0, evt_valid}, 8'h00);

    // R4 rising only
    send_cmd(8'h61);
    pin_to(1'b1); pin_to(1'b0); pin_to(1'b1); pin_to(1'b0);
    // R5 falling only
    send_cmd(8'h62);
    pin_to(1'b1); pin_to(1'b0); pin_to(1'b1); pin_to(1'b0);
    // R6 both edges
    send_cmd(8'h63);
    pin_to(1'b1); pin_to(1'b0);
    chk("R6 all delivered", 8'(exp_q.size()), 8'h00);

    // R8 stall: value held, order kept
    evt_ready = 1'b0;
    pin_to(1'b1); pin_to(1'b0); pin_to(1'b1);
    for (int i = 0; i < 4; i++) begin
      chk("R8 valid held", {7'b0, evt_valid}, 8'h01);
      chk("R8 byte held", evt_byte, 8'h31);
      wait_cyc(1);
    end
    evt_ready = 1'b1;
    wait_cyc(8);
    chk("R8 drained", 8'(exp_q.size()), 8'h00);

    // R9 overflow: 6 edges, 4 kept, lost sticky
    evt_ready = 1'b0;
    pin_to(1'b0); pin_to(1'b1); pin_to(1'b0); pin_to(1'b1); pin_to(1'b0); pin_to(1'b1);
    chk("R9 lost set", {7'b0, lost_event}, {7'b0, exp_lost});
    chk("R9 four kept", 8'(exp_q.size()), 8'h04);
    wait_cyc(10);
    chk("R9 lost sticky", {7'b0, lost_event}, 8'h01);
    evt_ready = 1'b1;
    wait_cyc(8);
    chk("R9 kept set delivered", 8'(exp_q.size()), 8'h00);
    chk("R9 lost after drain", {7'b0, lost_event}, 8'h01);
    send_cmd(8'h63);
    chk("R9 lost cleared", {7'b0, lost_event}, 8'h00);

    // R7 off discards pending, then stays silent
    evt_ready = 1'b0;
    pin_to(1'b0); pin_to(1'b1);
    chk("R7 pending before off", {7'b0, evt_valid}, 8'h01);
    send_cmd(8'h60);
    chk("R7 flushed", {7'b0, evt_valid}, 8'h00);
    evt_ready = 1'b1;
    pin_to(1'b0); pin_to(1'b1);
    chk("R7 silent when off", {7'b0, evt_valid}, 8'h00);

    wait_cyc(5);
    chk("R8 scoreboard empty", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule